// File: doc/BRIEF.md
# Caption Line Waveform Sequencer

This block produces the digital bit sequence for text captions carried on one video line per field. The video timing supplies a pulse at the reference point of each line, together with the current line number and a field flag. When captioning is enabled and the line is a caption line, the block emits a fixed frame. The frame opens with a clock run-in of seven bit periods, followed by two bit periods at blanking level and a start bit at logic 1. Two characters follow. Each character is seven data bits sent least significant bit first, then a generated parity bit that makes the count of ones in the character odd.

Two channels exist. The basic channel is sent on line 21 of the odd field. The extended channel is sent on line 284 of the even field. Each channel has two host-written 7-bit character registers. The host writes them during the line before the caption line. At the line reference of the caption line the block copies them into a frame register, so there is no frame of latency, and a write made during transmission only affects the next caption line. Bit timing comes from a fractional phase accumulator, so a bit lasts a non-integer number of pixel clocks (about 53.63 at 27 MHz) without drift building up. For the whole caption line the block also asserts a flag that makes the pixel path ignore its input.

The waveform leaves the block as a level plus a valid strobe. Shaping of the run-in into a sinusoid is left to the filter downstream.

Top module: `cc_line_seq`

## Requirements
- R1: No frame is sent and `pix_blank` stays low on every line other than line `LINE_BASIC` (21) with `field_odd`=1 and line `LINE_EXT` (284) with `field_odd`=0.
- R2: On a caption line with `cap_en` high, `pix_blank` is high from the first clock after the `line_start` edge until the next `line_start` edge.
- R3: `cc_valid` rises exactly `RUNIN_START` clock edges after the `line_start` edge of a caption line, and stays low before that.
- R4: The first 7 bit periods are the run-in. In each of them `cc_level` is 1 during the first half of the bit and 0 during the second half.
- R5: Bit periods 7 and 8 are at level 0. Bit period 9 is the start bit at level 1.
- R6: Bit periods 10 to 25 carry character 0 and then character 1. Each character is sent as data bits 0 to 6, then a parity bit chosen so the character holds an odd number of ones. The basic channel uses `wr_sel` 0 and 1. The extended channel uses `wr_sel` 2 and 3.
- R7: With n clocks counted from the first run-in cycle, the bit index is floor(n·`PHASE_INC`/2^`PHASE_W`). The half-bit phase is bit 0 of floor(2n·`PHASE_INC`/2^`PHASE_W`).
- R8: The characters sent are the register contents at the `line_start` edge of the caption line. A write made during transmission does not change the frame in progress, and it is sent on the next caption line.
- R9: A character register that holds zero is sent as seven zero bits followed by a parity bit of 1 (byte value 0x80).
- R10: With `cap_en` low no frame starts. Dropping `cap_en` during a caption line makes `cc_valid` and `pix_blank` fall on the next clock.
- R11: After reset, and outside bit periods 0 to 25 of a frame, `cc_valid` and `cc_level` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_en | input | 1 | Caption insertion enable |
| line_start | input | 1 | One-clock pulse at the reference point of each line |
| line_num | input | LINE_W | Line number, valid while `line_start` is high |
| field_odd | input | 1 | 1 in the odd field, 0 in the even field |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 2 | Register select: 0/1 basic chars 0/1, 2/3 extended chars 0/1 |
| wr_data | input | 7 | Character written by the host |
| cc_level | output | 1 | Caption waveform level |
| cc_valid | output | 1 | High while the frame is being sent |
| pix_blank | output | 1 | Override that forces the pixel path to ignore its input |

## Verification
The bench sweeps every 7-bit value through basic character 0, with its complement in character 1, and compares each clock against an arithmetic model. A parity that comes out even, or data sent most significant bit first, fails here. A phase step that rounds to whole clocks shows up as bit edges shifted by a clock. Lines one either side of each caption line, and each caption line number in the wrong field, are run to catch decode that ignores the field or is off by one. A write that lands mid-frame must leave the frame unchanged and appear on the next caption line, which catches a design that sends straight from the holding register. Zeroed registers must give a parity bit of 1. Dropping the enable mid-frame must stop the frame on the next clock.

// File: rtl/cc_pkg.sv
package cc_pkg;

    localparam int RUNIN_BITS = 7;
    localparam int BLANK_BITS = 2;
    localparam int START_BITS = 1;
    localparam int CHAR_DATA  = 7;
    localparam int NUM_CHARS  = 2;
    localparam int CHAR_BITS  = CHAR_DATA + 1;
    localparam int DATA_BITS  = NUM_CHARS * CHAR_BITS;
    localparam int HDR_BITS   = RUNIN_BITS + BLANK_BITS + START_BITS;
    localparam int FRAME_BITS = HDR_BITS + DATA_BITS;
    localparam int BIT_IDX_W  = $clog2(FRAME_BITS + 1);
    localparam int DATA_IDX_W = $clog2(DATA_BITS);
    localparam int NUM_REGS   = 2 * NUM_CHARS;
    localparam int SEL_W      = $clog2(NUM_REGS);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_RUNIN,
        ST_BLANK,
        ST_START,
        ST_DATA
    } cc_state_e;

    typedef struct packed {
        logic                 par;
        logic [CHAR_DATA-1:0] data;
    } cc_word_t;

    typedef struct packed {
        cc_word_t c1;
        cc_word_t c0;
    } cc_frame_t;

    function automatic cc_word_t with_odd_parity(input logic [CHAR_DATA-1:0] d);
        cc_word_t w;
        w.data = d;
        w.par  = ~(^d);
        return w;
    endfunction

    function automatic logic is_running(input cc_state_e s);
        return (s == ST_RUNIN) || (s == ST_BLANK) || (s == ST_START) || (s == ST_DATA);
    endfunction

endpackage

// File: rtl/cc_hold_regs.sv
module cc_hold_regs
    import cc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [SEL_W-1:0]     wr_sel,
    input  logic [CHAR_DATA-1:0] wr_data,
    input  logic                 load,
    input  logic                 load_ext,
    output cc_frame_t            frame
);
    logic [CHAR_DATA-1:0] hold [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_hold
        always_ff @(posedge clk) begin
            if (rst)
                hold[g] <= '0;
            else if (wr_en && (wr_sel == SEL_W'(g)))
                hold[g] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frame <= '0;
        end else if (load) begin
            if (load_ext) begin
                frame.c0 <= with_odd_parity(hold[2]);
                frame.c1 <= with_odd_parity(hold[3]);
            end else begin
                frame.c0 <= with_odd_parity(hold[0]);
                frame.c1 <= with_odd_parity(hold[1]);
            end
        end
    end
endmodule

// File: rtl/cc_bit_clock.sv
module cc_bit_clock #(
    parameter int PHASE_W   = 16,
    parameter int PHASE_INC = 1222
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic bit_tick,
    output logic half
);
    logic [PHASE_W-1:0] acc;
    logic [PHASE_W:0]   sum;

    assign sum      = {1'b0, acc} + (PHASE_W+1)'(PHASE_INC);
    assign bit_tick = run & sum[PHASE_W];
    assign half     = acc[PHASE_W-1];

    always_ff @(posedge clk) begin
        if (rst || !run)
            acc <= '0;
        else
            acc <= sum[PHASE_W-1:0];
    end
endmodule

// File: rtl/cc_line_fsm.sv
module cc_line_fsm
    import cc_pkg::*;
#(
    parameter int RUNIN_START = 284
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      abort,
    input  logic      bit_tick,
    input  logic      half,
    input  cc_frame_t frame,
    output logic      run,
    output logic      level
);
    localparam int WAIT_W = $clog2(RUNIN_START + 1);

    cc_state_e             state;
    logic [WAIT_W-1:0]     wcnt;
    logic [BIT_IDX_W-1:0]  bitn;
    logic [DATA_IDX_W-1:0] didx;
    logic [DATA_BITS-1:0]  fbits;

    assign run   = is_running(state);
    assign fbits = frame;
    assign didx  = DATA_IDX_W'(bitn - BIT_IDX_W'(HDR_BITS));

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            state <= ST_IDLE;
            wcnt  <= '0;
            bitn  <= '0;
        end else if (start) begin
            state <= ST_WAIT;
            wcnt  <= '0;
            bitn  <= '0;
        end else begin
            case (state)
                ST_WAIT: begin
                    if (wcnt == WAIT_W'(RUNIN_START - 1))
                        state <= ST_RUNIN;
                    else
                        wcnt <= wcnt + 1'b1;
                end
                ST_RUNIN, ST_BLANK, ST_START, ST_DATA: begin
                    if (bit_tick) begin
                        bitn <= bitn + 1'b1;
                        if (bitn == BIT_IDX_W'(RUNIN_BITS - 1))
                            state <= ST_BLANK;
                        else if (bitn == BIT_IDX_W'(RUNIN_BITS + BLANK_BITS - 1))
                            state <= ST_START;
                        else if (bitn == BIT_IDX_W'(HDR_BITS - 1))
                            state <= ST_DATA;
                        else if (bitn == BIT_IDX_W'(FRAME_BITS - 1))
                            state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        case (state)
            ST_RUNIN: level = ~half;
            ST_START: level = 1'b1;
            ST_DATA:  level = fbits[didx];
            default:  level = 1'b0;
        endcase
    end
endmodule

// File: rtl/cc_line_seq.sv
module cc_line_seq
    import cc_pkg::*;
#(
    parameter int LINE_W      = 10,
    parameter int LINE_BASIC  = 21,
    parameter int LINE_EXT    = 284,
    parameter int RUNIN_START = 284,
    parameter int PHASE_W     = 16,
    parameter int PHASE_INC   = 1222
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cap_en,
    input  logic                 line_start,
    input  logic [LINE_W-1:0]    line_num,
    input  logic                 field_odd,
    input  logic                 wr_en,
    input  logic [SEL_W-1:0]     wr_sel,
    input  logic [CHAR_DATA-1:0] wr_data,
    output logic                 cc_level,
    output logic                 cc_valid,
    output logic                 pix_blank
);
    logic      is_basic, is_ext, is_cap;
    logic      start, abort;
    logic      run, bit_tick, half;
    cc_frame_t frame_q;

    assign is_basic = field_odd  && (line_num == LINE_W'(LINE_BASIC));
    assign is_ext   = !field_odd && (line_num == LINE_W'(LINE_EXT));
    assign is_cap   = cap_en && (is_basic || is_ext);
    assign start    = line_start && is_cap;
    assign abort    = !cap_en || (line_start && !is_cap);

    always_ff @(posedge clk) begin
        if (rst || !cap_en)
            pix_blank <= 1'b0;
        else if (line_start)
            pix_blank <= is_cap;
    end

    cc_hold_regs u_hold (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .load     (start),
        .load_ext (is_ext),
        .frame    (frame_q)
    );

    cc_bit_clock #(
        .PHASE_W   (PHASE_W),
        .PHASE_INC (PHASE_INC)
    ) u_clk (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .bit_tick (bit_tick),
        .half     (half)
    );

    cc_line_fsm #(
        .RUNIN_START (RUNIN_START)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .abort    (abort),
        .bit_tick (bit_tick),
        .half     (half),
        .frame    (frame_q),
        .run      (run),
        .level    (cc_level)
    );

    assign cc_valid = run;
endmodule

// File: rtl/cc_line_seq_chk.sv
module cc_line_seq_chk #(
    parameter int LINE_W     = 10,
    parameter int LINE_BASIC = 21,
    parameter int LINE_EXT   = 284
) (
    input logic              clk,
    input logic              rst,
    input logic              cap_en,
    input logic              line_start,
    input logic [LINE_W-1:0] line_num,
    input logic              field_odd,
    input logic              cc_level,
    input logic              cc_valid,
    input logic              pix_blank,
    input logic [15:0]       frame
);
    logic cap_line;
    assign cap_line = (field_odd && line_num == LINE_W'(LINE_BASIC)) ||
                      (!field_odd && line_num == LINE_W'(LINE_EXT));

    assert_off_line_R1: assert property (@(posedge clk) disable iff (rst)
        (line_start && !cap_line) |=> !pix_blank);

    assert_valid_in_blank_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(cc_valid) |-> pix_blank);

    assert_runin_high_first_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(cc_valid) |-> cc_level);

    assert_frame_held_R8: assert property (@(posedge clk) disable iff (rst)
        (cc_valid && !line_start) |=> $stable(frame));

    assert_disable_stops_R10: assert property (@(posedge clk) disable iff (rst)
        !cap_en |=> (!cc_valid && !pix_blank));

    assert_quiet_level_R11: assert property (@(posedge clk) disable iff (rst)
        !cc_valid |-> !cc_level);
endmodule

bind cc_line_seq cc_line_seq_chk #(
    .LINE_W     (LINE_W),
    .LINE_BASIC (LINE_BASIC),
    .LINE_EXT   (LINE_EXT)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cap_en     (cap_en),
    .line_start (line_start),
    .line_num   (line_num),
    .field_odd  (field_odd),
    .cc_level   (cc_level),
    .cc_valid   (cc_valid),
    .pix_blank  (pix_blank),
    .frame      (frame_q)
);

// File: tb/cc_line_seq_tb.sv
module cc_line_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int D          = 8;
    localparam int INC        = 12000;
    localparam int PW         = 16;
    localparam int LINE_LEN   = 160;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cap_en = 1'b0;
    logic       line_start = 1'b0;
    logic [9:0] line_num = '0;
    logic       field_odd = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [6:0] wr_data = '0;
    logic       cc_level, cc_valid, pix_blank;

    int checks = 0;
    int errors = 0;
    logic [6:0] sh [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    cc_line_seq #(
        .LINE_W      (10),
        .LINE_BASIC  (21),
        .LINE_EXT    (284),
        .RUNIN_START (D),
        .PHASE_W     (PW),
        .PHASE_INC   (INC)
    ) u_dut (
        .clk        (clk),
        .rst        (rst),
        .cap_en     (cap_en),
        .line_start (line_start),
        .line_num   (line_num),
        .field_odd  (field_odd),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .cc_level   (cc_level),
        .cc_valid   (cc_valid),
        .pix_blank  (pix_blank)
    );

    task automatic wr(input int sel, input logic [6:0] v);
        wr_en = 1'b1; wr_sel = 2'(sel); wr_data = v;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
        sh[sel] = v;
    endtask

    task automatic run_line(input int ln, input bit odd, input bit en,
                            input int drop_at, input int mid_wr, input string tag);
        logic [6:0]  b0, b1;
        logic [15:0] f;
        bit cap, act, ev, el, bv, bl, bb;
        int n, b, h, msel;
        string sec;
        b0 = odd ? sh[0] : sh[2];
        b1 = odd ? sh[1] : sh[3];
        f  = {~(^b1), b1, ~(^b0), b0};
        cap = en && ((odd && ln == 21) || (!odd && ln == 284));
        msel = odd ? 0 : 2;
        bv = 0; bl = 0; bb = 0;
        cap_en = en; line_num = 10'(ln); field_odd = odd; line_start = 1'b1;
        for (int m = 1; m <= LINE_LEN; m++) begin
            @(posedge clk); @(negedge clk);
            line_start = 1'b0;
            wr_en = 1'b0;
            act = cap && (drop_at == 0 || m <= drop_at);
            n = m - D - 1;
            // R7: bit index and half phase from the accumulator arithmetic
            b = (n >= 0) ? ((n * INC) >>> PW) : -1;
            h = (n >= 0) ? (((n * INC) >>> (PW - 1)) & 1) : 0;
            ev = act && n >= 0 && b < 26;
            if (!ev)        el = 1'b0;
            else if (b < 7) el = (h == 0);
            else if (b < 9) el = 1'b0;
            else if (b == 9) el = 1'b1;
            else            el = f[b - 10];
            sec = !cap ? "R1" : (n < 0) ? "R3" : (b < 7) ? "R4" :
                  (b < 10) ? "R5" : (b < 26) ? "R6" : "R11";
            if (cc_valid !== ev && !bv) begin
                bv = 1;
                $display("FAIL %s/%s cc_valid line %0d m=%0d actual %b expected %b",
                         sec, tag, ln, m, cc_valid, ev);
            end
            if (cc_level !== el && !bl) begin
                bl = 1;
                $display("FAIL %s/%s cc_level line %0d m=%0d bit=%0d actual %b expected %b",
                         sec, tag, ln, m, b, cc_level, el);
            end
            if (pix_blank !== act && !bb) begin
                bb = 1;
                $display("FAIL R2/%s pix_blank line %0d m=%0d actual %b expected %b",
                         tag, ln, m, pix_blank, act);
            end
            if (m == mid_wr) begin
                wr_en = 1'b1; wr_sel = 2'(msel); wr_data = 7'h55;
            end
            if (m == drop_at) cap_en = 1'b0;
        end
        checks += 3;
        errors += int'(bv) + int'(bl) + int'(bb);
        if (mid_wr != 0) sh[msel] = 7'h55;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) sh[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        checks++;
        if (cc_valid !== 1'b0 || cc_level !== 1'b0 || pix_blank !== 1'b0) begin
            errors++;
            $display("FAIL R11 reset outputs actual %b%b%b expected 000",
                     cc_valid, cc_level, pix_blank);
        end
        wr(0, 7'h41); wr(1, 7'h42); wr(2, 7'h61); wr(3, 7'h62);
        // R1: neighbours and wrong fields
        run_line(20, 1, 1, 0, 0, "R1");
        run_line(22, 1, 1, 0, 0, "R1");
        run_line(21, 0, 1, 0, 0, "R1");
        run_line(284, 1, 1, 0, 0, "R1");
        run_line(283, 0, 1, 0, 0, "R1");
        run_line(285, 0, 1, 0, 0, "R1");
        // R6: basic and extended channels
        run_line(21, 1, 1, 0, 0, "R6");
        run_line(284, 0, 1, 0, 0, "R6");
        // R9: null characters
        wr(0, 7'h00); wr(1, 7'h00);
        run_line(21, 1, 1, 0, 0, "R9");
        wr(2, 7'h00); wr(3, 7'h00);
        run_line(284, 0, 1, 0, 0, "R9");
        // R8: write during transmission, then next caption line
        wr(0, 7'h13); wr(1, 7'h7F);
        run_line(21, 1, 1, 0, 60, "R8");
        run_line(21, 1, 1, 0, 0, "R8");
        run_line(284, 0, 1, 0, 30, "R8");
        run_line(284, 0, 1, 0, 0, "R8");
        // R10: disabled and dropped mid-frame
        run_line(21, 1, 0, 0, 0, "R10");
        run_line(284, 0, 1, 40, 0, "R10");
        run_line(21, 1, 1, 5, 0, "R10");
        // R7: sweep of all basic char-0 values
        for (int i = 0; i < 128; i++) begin
            wr(0, 7'(i)); wr(1, 7'(127 - i));
            run_line(21, 1, 1, 0, 0, "R7");
        end
        for (int i = 0; i < 128; i += 9) begin
            wr(2, 7'(127 - i)); wr(3, 7'(i));
            run_line(284, 0, 1, 0, 0, "R6");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule